// File: doc/BRIEF.md
# Random Wall Column Generator

This block fills an 8-row by 8-column scrolling playfield with obstacle columns. Each cell is one bit, and any mix of cells may be set at once. A small counter runs on its own enable and is never reset by the game. On some shift pulses its upper three bits are captured into a hole register. That captured value is decoded to a one-hot column and then inverted, which gives a wall with exactly one open cell.

Every row has its own serial-in parallel-out register. All rows shift together on a shift strobe, so a whole column moves left by one position. Columns enter at the right edge. A phase bit toggles on each shift. The wall phase injects the decoded wall column. The blank phase injects an all-zero column and captures a new hole value. The playfield and the second column from the left (the column the player occupies) are brought out.

Top module: `wall_gen_top`

## Requirements
- R1: After reset, `field_o` and `col2_o` are all zero, the phase is wall, and the counter and the hole register both hold 0.
- R2: The 4-bit counter increments by one, modulo 16, on each clock edge where `cnt_en_i` is high. Otherwise it holds its value.
- R3: On a shift in the blank phase, the hole register loads counter bits [3:1], using the counter value before that edge. At every other edge the hole register holds.
- R4: A wall column has row r set for every r except the row equal to the hole register value, so exactly seven cells are set.
- R5: The phase toggles on every shift and only on a shift. A shift in the wall phase injects the wall column. A shift in the blank phase injects an all-zero column.
- R6: On a shift, column c takes the old value of column c+1, column 7 (rightmost) takes the injected column, and the old column 0 is dropped. Without a shift, the field holds its value, even while the counter runs.
- R7: `col2_o[r]` equals the cell at row r, column 1.
- R8: Cell (row r, column c) is `field_o[r*8 + c]`. Column 0 is the leftmost column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cnt_en_i | input | 1 | Advance enable for the fast counter |
| shift_i | input | 1 | Shift strobe for the playfield |
| field_o | output | 64 | Playfield, bit r*8+c is row r, column c |
| col2_o | output | 8 | Column 1 (second from left), one bit per row |

## Verification
The hardest case to reach is a hole in the bottom row (hole value 7). Getting there needs the counter at 14 or 15 exactly when a blank-phase shift happens, because the hole value is only visible one shift later. A directed sequence runs the counter 14 steps after reset, then issues two shifts, then a third. That places the bottom-row gap at the right edge. Random bursts with independent enable and shift patterns cover the other holes and the long scrolls.

// File: rtl/wall_gen_pkg.sv
package wall_gen_pkg;
  typedef enum logic {PH_WALL = 1'b0, PH_BLANK = 1'b1} phase_e;
endpackage

// File: rtl/wg_fast_cnt.sv
module wg_fast_cnt #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_o <= '0;
    else if (en_i) cnt_o <= cnt_o + 1'b1;
  end

  assert_cnt_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> cnt_o == W'($past(cnt_o) + 1'b1));
  assert_cnt_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(cnt_o));
endmodule

// File: rtl/wg_hole_sampler.sv
module wg_hole_sampler #(
  parameter int CNT_W = 4,
  parameter int SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [SEL_W-1:0] hole_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hole_o <= '0;
    else if (load_i) hole_o <= cnt_i[CNT_W-1 -: SEL_W];
  end

  assert_hole_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> hole_o == $past(cnt_i[CNT_W-1 -: SEL_W]));
  assert_hole_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(hole_o));
endmodule

// File: rtl/wg_col_encoder.sv
module wg_col_encoder #(
  parameter int ROWS  = 8,
  parameter int SEL_W = 3
) (
  input  logic [SEL_W-1:0] hole_i,
  output logic [ROWS-1:0]  col_o
);
  always_comb begin
    col_o = '1;
    for (int r = 0; r < ROWS; r++)
      if (SEL_W'(r) == hole_i) col_o[r] = 1'b0;
  end

  always_comb begin
    if (!$isunknown(hole_i))
      assert_one_gap_R4: assert ($countones(col_o) == ROWS - 1);
  end
endmodule

// File: rtl/wg_row_shifter.sv
module wg_row_shifter #(
  parameter int COLS = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            shift_i,
  input  logic            din_i,
  output logic [COLS-1:0] row_o
);
  // bit c is column c, bit COLS-1 is the entry edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      row_o <= '0;
    else if (shift_i) row_o <= {din_i, row_o[COLS-1:1]};
  end

  assert_row_move_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |=> (row_o[COLS-2:0] == $past(row_o[COLS-1:1])) && (row_o[COLS-1] == $past(din_i)));
  assert_row_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> $stable(row_o));
endmodule

// File: rtl/wall_gen_top.sv
module wall_gen_top #(
  parameter int ROWS = 8,
  parameter int COLS = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnt_en_i,
  input  logic             shift_i,
  output logic [ROWS*COLS-1:0] field_o,
  output logic [ROWS-1:0]  col2_o
);
  import wall_gen_pkg::*;

  localparam int SEL_W    = $clog2(ROWS);
  localparam int CNT_W    = SEL_W + 1;
  localparam int PLAY_COL = 1;

  phase_e           phase_q;
  logic [CNT_W-1:0] cnt;
  logic [SEL_W-1:0] hole;
  logic [ROWS-1:0]  wall_col;
  logic [ROWS-1:0]  inj_col;
  logic [ROWS-1:0]  edge_col;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      phase_q <= PH_WALL;
    else if (shift_i) phase_q <= (phase_q == PH_WALL) ? PH_BLANK : PH_WALL;
  end

  wg_fast_cnt #(.W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .en_i(cnt_en_i), .cnt_o(cnt)
  );

  wg_hole_sampler #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_smp (
    .clk_i, .rst_ni,
    .load_i(shift_i && (phase_q == PH_BLANK)),
    .cnt_i(cnt), .hole_o(hole)
  );

  wg_col_encoder #(.ROWS(ROWS), .SEL_W(SEL_W)) u_enc (
    .hole_i(hole), .col_o(wall_col)
  );

  assign inj_col = (phase_q == PH_WALL) ? wall_col : '0;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic [COLS-1:0] row;
    wg_row_shifter #(.COLS(COLS)) u_row (
      .clk_i, .rst_ni, .shift_i, .din_i(inj_col[r]), .row_o(row)
    );
    assign field_o[r*COLS +: COLS] = row;
    assign col2_o[r]   = row[PLAY_COL];
    assign edge_col[r] = row[COLS-1];
  end

  assert_phase_flip_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |=> phase_q != $past(phase_q));
  assert_phase_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> $stable(phase_q));
  assert_wall_enters_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && phase_q == PH_WALL) |=> $countones(edge_col) == ROWS - 1);
  assert_blank_enters_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && phase_q == PH_BLANK) |=> edge_col == '0);
endmodule

// File: tb/wall_gen_top_tb.sv
module wall_gen_top_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cnt_en_i = 1'b0;
  logic        shift_i = 1'b0;
  logic [63:0] field_o;
  logic [7:0]  col2_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [7:0] m_row [8];
  logic [3:0] m_cnt;
  logic [2:0] m_hole;
  logic       m_blank;

  always #2 clk_i = ~clk_i;

  wall_gen_top u_dut (.clk_i, .rst_ni, .cnt_en_i, .shift_i, .field_o, .col2_o);

  function automatic logic [63:0] pack_field();
    logic [63:0] f;
    for (int r = 0; r < 8; r++) f[r*8 +: 8] = m_row[r];
    return f;
  endfunction

  function automatic logic [7:0] play_col();
    logic [7:0] c;
    for (int r = 0; r < 8; r++) c[r] = m_row[r][1];
    return c;
  endfunction

  function automatic logic [7:0] wall_of(logic [2:0] h);
    return ~(8'd1 << h);
  endfunction

  task automatic model_reset();
    for (int r = 0; r < 8; r++) m_row[r] = '0;
    m_cnt = '0; m_hole = '0; m_blank = 1'b0;
  endtask

  task automatic model_step(logic en, logic sh);
    logic [7:0] inj;
    if (sh) begin
      inj = m_blank ? 8'h00 : wall_of(m_hole);
      if (m_blank) m_hole = m_cnt[3:1];
      for (int r = 0; r < 8; r++) m_row[r] = {inj[r], m_row[r][7:1]};
      m_blank = ~m_blank;
    end
    if (en) m_cnt = m_cnt + 1'b1;
  endtask

  task automatic chk64(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk8(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step(logic en, logic sh, string tag);
    cnt_en_i = en; shift_i = sh;
    @(posedge clk_i);
    model_step(en, sh);
    @(negedge clk_i);
    chk64({tag, " field R6 R4 R5"}, field_o, pack_field());
    chk8({tag, " col2 R7"}, col2_o, play_col());
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; cnt_en_i = 0; shift_i = 0;
    @(negedge clk_i); @(negedge clk_i);
    model_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  initial begin
    logic [63:0] snap;
    void'($urandom(32'd1234));
    do_reset();
    chk64("R1 reset field", field_o, 64'h0);
    chk8("R1 reset col2", col2_o, 8'h0);

    // R8, R1: first wall uses hole 0 -> rows 1..7 set at column 7
    step(0, 1, "R8 first wall");
    chk64("R8 cell index", field_o, 64'h8080_8080_8080_8000);

    // R6: counter running without shift leaves field alone
    snap = field_o;
    for (int i = 0; i < 5; i++) step(1, 0, "R6 hold");
    chk64("R6 hold no shift", field_o, snap);

    // R2 R3: corner hole 7 -> counter 14 before blank-phase sample
    do_reset();
    for (int i = 0; i < 14; i++) step(1, 0, "R2 count");
    step(0, 1, "R3 wall hole0");
    step(0, 1, "R3 blank sample");
    step(0, 1, "R4 wall hole7");
    chk8("R4 hole7 edge", {field_o[63], field_o[55], field_o[47], field_o[39],
                           field_o[31], field_o[23], field_o[15], field_o[7]}, 8'h7F);

    // R2: wrap of counter, sample after 16+2 steps gives hole 1
    do_reset();
    for (int i = 0; i < 18; i++) step(1, 0, "R2 wrap");
    step(0, 1, "R2 wrap wall");
    step(0, 1, "R2 wrap blank");
    step(0, 1, "R2 wrap hole1");
    chk8("R2 wrap hole1 edge", {field_o[63], field_o[55], field_o[47], field_o[39],
                                field_o[31], field_o[23], field_o[15], field_o[7]}, 8'hFD);

    // random mix with shift and count enable
    for (int i = 0; i < 3000; i++)
      step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 2) == 0), "rand");
    // dense shifting burst
    for (int i = 0; i < 500; i++)
      step(1'($urandom_range(0, 1)), 1'b1, "burst");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule